// File: doc/BRIEF.md
# Single-Vector Interrupt Acceptance Sequencer

This block decides, at each opcode fetch, whether the fetch goes to memory or is replaced by an implied restart-call. It watches an asynchronous, active-low, level-sensitive interrupt pin through a synchronizer. It latches the synchronized level at a sample strobe that the decoder raises once inside every instruction. It also keeps the interrupt-enable flag, which the decoded enable and disable strobes change.

When the fetch unit raises its fetch request and a request was sampled during the instruction that just ended, the call is taken if the enable flag is set and no enable shadow is active. In the same cycle the block withholds the memory fetch. It emits a two-byte stack write holding the address the fetch would have used, lowers the stack pointer by two and loads a fixed handler address into the program counter. It clears the enable flag in the same step.

After an enable instruction the next fetch cannot be replaced. A handler that ends with enable followed by return therefore always gets back to the interrupted code. If the pin is still low there, the call is taken again after the first instruction that follows.

Top module: `irq_accept_seq`

## Requirements
- R1: The pin passes through a two-flop synchronizer. A sample strobe at the first or second rising edge after the pin changes still captures the old level. From the third edge on it captures the new level.
- R2: A fetch request is replaced by the implied call when all three of these hold: a low pin level was captured during the current instruction, the enable flag is set, and no shadow is active. In that cycle `take_irq`=1, `fetch_go`=0, `pc_we`=1 and `pc_out`=0x0038.
- R3: Taking the implied call clears the enable flag. Later fetches are not replaced until an enable strobe sets the flag again.
- R4: In the cycle of the call, `push_we`=1. The high byte of `next_pc` goes to address `sp_in`-1 and the low byte goes to `sp_in`-2. `sp_we`=1 and `sp_out`=`sp_in`-2. Without a call, `push_we` and `sp_we` are 0.
- R5: An enable strobe sets the flag and arms a shadow. The shadow blocks replacement of exactly the next fetch, and that fetch proceeds to memory.
- R6: A disable strobe clears the flag at once and cancels any shadow. A pending request at the next fetch is then not taken.
- R7: While `rst_n` is low, `pc_we`=1, `pc_out`=0x0000 and `take_irq`=0. After reset the enable flag is clear.
- R8: The request is level-sensitive and is resampled in every instruction. Each fetch discards the captured level. An instruction whose sample sees the pin high, or that has no sample strobe, leaves nothing to take at its fetch. A pin still low after a return is taken at the fetch that ends the following instruction.
- R9: When no call is taken, `fetch_go` equals `fetch_req`. Strobes and fetch requests never share a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_n | input | 1 | Asynchronous active-low interrupt pin |
| sample_stb | input | 1 | Pin sample point inside the current instruction |
| ei_stb | input | 1 | Decoded enable instruction |
| di_stb | input | 1 | Decoded disable instruction |
| fetch_req | input | 1 | Fetch unit wants the next opcode |
| next_pc | input | 16 | Address of the opcode to be fetched |
| sp_in | input | 16 | Current stack pointer |
| fetch_go | output | 1 | Memory fetch may proceed |
| take_irq | output | 1 | Fetch replaced by the implied call |
| push_we | output | 1 | Two-byte stack write enable |
| push_hi_addr | output | 16 | Address of the high return byte |
| push_hi_data | output | 8 | High return byte |
| push_lo_addr | output | 16 | Address of the low return byte |
| push_lo_data | output | 8 | Low return byte |
| sp_we | output | 1 | Stack pointer load |
| sp_out | output | 16 | New stack pointer |
| pc_we | output | 1 | Program counter load |
| pc_out | output | 16 | Program counter load value |

## Verification
The bench changes the pin and then samples it immediately. A design with a missing or extra synchronizer stage would take the call one instruction too early or too late. An enable strobe followed by a fetch with the pin held low goes after the shadow. A design without the shadow re-enters the handler before the return, and one whose shadow lasts too long skips a legal acceptance. Disable strobes, instructions without a sample and pins released before the sample catch a design that keeps a stale request or delays the disable. Stack-pointer values near zero check that the return-byte addresses wrap and that the high byte sits above the low one.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PUSH_BYTES = ADDR_W / BYTE_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    addr_t hi_addr;
    byte_t hi_data;
    addr_t lo_addr;
    byte_t lo_data;
  } push_pair_t;

  // high return byte sits one below the current stack pointer
  function automatic addr_t stack_hi_slot(input addr_t sp);
    return sp - addr_t'(1);
  endfunction

  function automatic addr_t stack_lo_slot(input addr_t sp);
    return sp - addr_t'(2);
  endfunction

  function automatic addr_t sp_after_call(input addr_t sp);
    return sp - addr_t'(PUSH_BYTES);
  endfunction

  function automatic byte_t upper_byte(input addr_t a);
    return a[ADDR_W-1 -: BYTE_W];
  endfunction

  function automatic byte_t lower_byte(input addr_t a);
    return a[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic req_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= pin_n;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], pin_n};
      end
    end
  endgenerate

  assign req_o = ~chain_q[STAGES-1];

  // a falling pin cannot reach the output within one edge
  assert_sync_lag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_n) |=> !req_o);
endmodule

// File: rtl/irq_enable_ctl.sv
module irq_enable_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ei_stb,
  input  logic di_stb,
  input  logic fetch_req,
  input  logic take_i,
  output logic ie_o,
  output logic shadow_o
);
  logic ie_q, shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q     <= 1'b0;
      shadow_q <= 1'b0;
    end else if (di_stb) begin
      ie_q     <= 1'b0;
      shadow_q <= 1'b0;
    end else if (ei_stb) begin
      ie_q     <= 1'b1;
      shadow_q <= 1'b1;
    end else if (fetch_req) begin
      shadow_q <= 1'b0;
      if (take_i) ie_q <= 1'b0;
    end
  end

  assign ie_o     = ie_q;
  assign shadow_o = shadow_q;

  assert_take_clears_ie_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && !ei_stb |=> !ie_q);
  assert_enable_arms_shadow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ei_stb && !di_stb |=> ie_q && shadow_q);
  assert_shadow_one_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !ei_stb |=> !shadow_q);
  assert_disable_now_R6: assert property (@(posedge clk) disable iff (!rst_n)
    di_stb |=> !ie_q && !shadow_q);
endmodule

// File: rtl/irq_push_gen.sv
module irq_push_gen
  import irq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  addr_t      ret_pc,
  input  addr_t      sp_cur,
  output logic       push_we,
  output push_pair_t push,
  output logic       sp_we,
  output addr_t      sp_new
);
  always_comb begin
    push_we      = en;
    sp_we        = en;
    push.hi_addr = stack_hi_slot(sp_cur);
    push.hi_data = upper_byte(ret_pc);
    push.lo_addr = stack_lo_slot(sp_cur);
    push.lo_data = lower_byte(ret_pc);
    sp_new       = sp_after_call(sp_cur);
  end

  // the new stack pointer lands on the last byte written
  assert_sp_on_low_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push_we |-> (sp_new == push.lo_addr) && (push.hi_addr == push.lo_addr + addr_t'(1)));
endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq
  import irq_seq_pkg::*;
#(
  parameter addr_t       VEC_ADDR    = 16'h0038,
  parameter addr_t       RESET_PC    = 16'h0000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                irq_n,
  input  logic                sample_stb,
  input  logic                ei_stb,
  input  logic                di_stb,
  input  logic                fetch_req,
  input  logic [ADDR_W-1:0]   next_pc,
  input  logic [ADDR_W-1:0]   sp_in,
  output logic                fetch_go,
  output logic                take_irq,
  output logic                push_we,
  output logic [ADDR_W-1:0]   push_hi_addr,
  output logic [BYTE_W-1:0]   push_hi_data,
  output logic [ADDR_W-1:0]   push_lo_addr,
  output logic [BYTE_W-1:0]   push_lo_data,
  output logic                sp_we,
  output logic [ADDR_W-1:0]   sp_out,
  output logic                pc_we,
  output logic [ADDR_W-1:0]   pc_out
);
  logic       req_live;
  logic       req_seen_q;
  logic       ie, shadow;
  logic       take;
  push_pair_t push;

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n (irq_n),
    .req_o (req_live)
  );

  // level captured once per instruction, dropped at its fetch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          req_seen_q <= 1'b0;
    else if (fetch_req)  req_seen_q <= 1'b0;
    else if (sample_stb) req_seen_q <= req_live;
  end

  irq_enable_ctl u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .ei_stb    (ei_stb),
    .di_stb    (di_stb),
    .fetch_req (fetch_req),
    .take_i    (take),
    .ie_o      (ie),
    .shadow_o  (shadow)
  );

  assign take = fetch_req & req_seen_q & ie & ~shadow;

  irq_push_gen u_push (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (take),
    .ret_pc  (next_pc),
    .sp_cur  (sp_in),
    .push_we (push_we),
    .push    (push),
    .sp_we   (sp_we),
    .sp_new  (sp_out)
  );

  assign push_hi_addr = push.hi_addr;
  assign push_hi_data = push.hi_data;
  assign push_lo_addr = push.lo_addr;
  assign push_lo_data = push.lo_data;

  assign take_irq = take;
  assign fetch_go = fetch_req & ~take;
  assign pc_we    = ~rst_n | take;
  assign pc_out   = take ? VEC_ADDR : RESET_PC;

  assert_capture_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |=> !req_seen_q);
  assert_take_after_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ie && push_we && sp_we);
  assert_no_take_in_shadow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && shadow |-> fetch_go);
endmodule

// File: tb/irq_accept_seq_bench.sv
module irq_accept_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, irq_n = 1;
  logic        sample_stb = 0, ei_stb = 0, di_stb = 0, fetch_req = 0;
  logic [15:0] next_pc = 0, sp_in = 0;
  logic        fetch_go, take_irq, push_we, sp_we, pc_we;
  logic [15:0] push_hi_addr, push_lo_addr, sp_out, pc_out;
  logic [7:0]  push_hi_data, push_lo_data;

  irq_accept_seq u_irq_accept_seq (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .sample_stb(sample_stb),
    .ei_stb(ei_stb), .di_stb(di_stb), .fetch_req(fetch_req),
    .next_pc(next_pc), .sp_in(sp_in), .fetch_go(fetch_go), .take_irq(take_irq),
    .push_we(push_we), .push_hi_addr(push_hi_addr), .push_hi_data(push_hi_data),
    .push_lo_addr(push_lo_addr), .push_lo_data(push_lo_data), .sp_we(sp_we),
    .sp_out(sp_out), .pc_we(pc_we), .pc_out(pc_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int  n_tests = 0, n_fail = 0;
  int  edges_since = 100;
  bit  prev_pin = 1;
  bit  m_ie = 0, m_shadow = 0, m_req = 0;
  bit  finished = 0;
  int unsigned seed = 32'h5eed_1234;

  always @(posedge clk) edges_since++;

  function automatic logic [15:0] exp_hi(input logic [15:0] sp);
    return sp + 16'hFFFF;
  endfunction
  function automatic logic [15:0] exp_lo(input logic [15:0] sp);
    return sp + 16'hFFFE;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_pin(input bit v);
    prev_pin = irq_n;
    irq_n = v;
    edges_since = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one instruction: sample/strobe cycle, then the fetch cycle
  task automatic instr(input bit s, input bit e, input bit d,
                       input logic [15:0] pc, input logic [15:0] sp, input string tag);
    bit seen_low, exp_take;
    seen_low = (edges_since >= 2) ? !irq_n : !prev_pin;
    sample_stb = s; ei_stb = e; di_stb = d;
    #1 chk({tag, " no call outside fetch R9"}, take_irq, 0);
    @(negedge clk);
    sample_stb = 0; ei_stb = 0; di_stb = 0;
    if (s) m_req = seen_low;
    if (d) begin m_ie = 0; m_shadow = 0; end
    else if (e) begin m_ie = 1; m_shadow = 1; end
    fetch_req = 1; next_pc = pc; sp_in = sp;
    exp_take = m_ie && m_req && !m_shadow;
    #1;
    chk({tag, " take R2"}, take_irq, exp_take);
    chk({tag, " fetch_go R9"}, fetch_go, !exp_take);
    chk({tag, " pc_we R2"}, pc_we, exp_take);
    chk({tag, " push_we R4"}, push_we, exp_take);
    chk({tag, " sp_we R4"}, sp_we, exp_take);
    if (exp_take) begin
      chk({tag, " vector R2"}, pc_out, 16'h0038);
      chk({tag, " hi addr R4"}, push_hi_addr, exp_hi(sp));
      chk({tag, " hi data R4"}, push_hi_data, pc[15:8]);
      chk({tag, " lo addr R4"}, push_lo_addr, exp_lo(sp));
      chk({tag, " lo data R4"}, push_lo_data, pc[7:0]);
      chk({tag, " sp out R4"}, sp_out, exp_lo(sp));
    end
    @(negedge clk);
    fetch_req = 0;
    m_req = 0; m_shadow = 0;
    if (exp_take) m_ie = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("reset pc_we R7", pc_we, 1);
    chk("reset pc_out R7", pc_out, 16'h0000);
    chk("reset take R7", take_irq, 0);
    rst_n = 1;
    idle(2);
    // R7: flag clear after reset, so a low pin is not taken
    set_pin(0); idle(3);
    instr(1, 0, 0, 16'h1234, 16'h8000, "R7 flag clear");
    set_pin(1); idle(3);
    // R1: synchronizer lag
    instr(0, 1, 0, 16'h0100, 16'h8000, "R1 enable");
    instr(0, 0, 0, 16'h0101, 16'h8000, "R1 after shadow");
    set_pin(0);
    instr(1, 0, 0, 16'h0102, 16'h8000, "R1 too early");
    instr(1, 0, 0, 16'h0103, 16'h8000, "R1 now visible");
    // R3: flag now clear, pin still low
    instr(1, 0, 0, 16'h0038, 16'h7FFE, "R3 in handler");
    // R5: enable then return, shadow blocks, then retaken (R8)
    instr(1, 1, 0, 16'h0039, 16'h7FFE, "R5 enable in handler");
    instr(1, 0, 0, 16'h0104, 16'h8000, "R8 retaken after return");
    // R6: disable with request pending
    instr(0, 1, 0, 16'h0038, 16'h7FFE, "R6 enable");
    instr(1, 0, 1, 16'h0200, 16'h7FFE, "R6 disable");
    instr(0, 1, 0, 16'h0201, 16'h7FFE, "R6 reenable");
    // R8: no sample leaves nothing to take
    instr(0, 0, 0, 16'h0202, 16'h7FFE, "R8 no sample");
    // R4: stack near zero wraps
    instr(1, 0, 0, 16'hABCD, 16'h0001, "R4 wrap");
    // R8: pin released before sample
    instr(0, 1, 0, 16'h0300, 16'h0000, "R8 enable");
    set_pin(1); idle(3);
    instr(1, 0, 0, 16'h0301, 16'h0000, "R8 released");
    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      bit s, e, d;
      r = $urandom(seed + i);
      if (r[1:0] == 0) begin set_pin(!irq_n); idle(2); end
      s = (r[4:2] != 0);
      e = (r[7:5] == 0);
      d = !e && (r[10:8] == 0);
      instr(s, e, d, r[31:16], 16'(r[27:12]), "rand");
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule